// File: doc/BRIEF.md
# Outstanding Request Table

The block tracks every split-transaction request that is still waiting for its data on a shared bus. There is one copy per cache controller. A request that wins the bus is given a tag, and the table stores it in the slot whose index equals that tag. The slot holds the block address, the request kind, this cache's snoop result once it is known, and two flags. The grab flag means this cache wants the returning data. The origin flag means this cache issued the request. When a response with that tag appears, the slot is released and the tag can be handed out again.

The processor side presents each new request to the table before issuing it. The table compares the address with every live slot in the same cycle. It answers with exactly one of three outcomes:
- issue: the request may go to the bus.
- merge: the request is a read that rides on a pending read to the same block, so the grab flag of that slot is set.
- retry: the request must wait, either because of a conflicting pending request or because every tag is in use.

Bus-side lookups are flagged the same way, so that a race with a request from another cache is visible. When a response arrives, the stored flags and snoop result are presented with it.

Top module: `ort_table`

## Requirements
- R1: After reset every slot is empty: `valid_o` is 0, `full_o` is 0, and no response lookup hits.
- R2: A bus request of kind read (0) or exclusive read (1) with tag t fills slot t on the next clock edge. A later response with tag t reports `rsp_hit_o`=1, with `rsp_orig_o` and `rsp_grab_o` both equal to the request's own flag.
- R3: A bus request of kind upgrade (2) or writeback (3) creates no slot, because it never waits for a data response.
- R4: A response with tag t empties slot t on the next edge, and the tag may be reused. If a new request with tag t arrives in the same cycle, the new request occupies the slot.
- R5: A snoop result for a live slot is stored. It is reported on `rsp_snoop_o` with `rsp_snoop_known_o`=1 when that slot's response appears; until then `rsp_snoop_known_o` stays 0.
- R6: `bus_hit_o` is 1 in the same cycle when a valid bus request carries the address of a live slot.
- R7: A processor request whose address matches no live slot, while some tag is free, gets `cpu_issue_o`=1.
- R8: A processor read that matches a live read slot gets `cpu_merge_o`=1. This is allowed even when the table is full. It sets that slot's grab flag and leaves its origin flag unchanged.
- R9: A processor request that matches a live slot, where either side is not a plain read, gets `cpu_retry_o`=1. After that slot is freed, the same request gets `cpu_issue_o`=1.
- R10: With all slots live, `full_o`=1 and an unmatched processor request gets `cpu_retry_o`=1.
- R11: While `cpu_req_valid_i` is 1, exactly one of issue, merge and retry is 1. All three are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_valid_i | input | 1 | A request is on the bus this cycle |
| bus_req_tag_i | input | TAG_W | Tag assigned to that request |
| bus_req_addr_i | input | ADDR_W | Block address of that request |
| bus_req_kind_i | input | 2 | 0 read, 1 exclusive read, 2 upgrade, 3 writeback |
| bus_req_own_i | input | 1 | The request was issued by this cache |
| snoop_valid_i | input | 1 | Snoop result available |
| snoop_tag_i | input | TAG_W | Tag the snoop result belongs to |
| snoop_state_i | input | 2 | Local snoop state to store |
| rsp_valid_i | input | 1 | A response is on the bus |
| rsp_tag_i | input | TAG_W | Tag carried by the response |
| cpu_req_valid_i | input | 1 | Processor wants to issue a request |
| cpu_req_addr_i | input | ADDR_W | Block address of the processor request |
| cpu_req_kind_i | input | 2 | Kind of processor request, same coding as the bus |
| cpu_issue_o | output | 1 | Request may go to the bus |
| cpu_merge_o | output | 1 | Request merged into a pending read |
| cpu_retry_o | output | 1 | Request must be held back |
| bus_hit_o | output | 1 | Bus request address matches a live slot |
| full_o | output | 1 | All slots live |
| valid_o | output | 2**TAG_W | Live flag for each slot |
| rsp_hit_o | output | 1 | Response tag names a live slot |
| rsp_grab_o | output | 1 | Grab flag of that slot |
| rsp_orig_o | output | 1 | Origin flag of that slot |
| rsp_snoop_known_o | output | 1 | Stored snoop result is valid |
| rsp_snoop_o | output | 2 | Stored snoop state |

## Verification
The lookup results are combinational on the current table contents. These are issue, merge, retry, `bus_hit_o`, `full_o` and the response fields. They are due in the same cycle as the stimulus, and the bench samples them two time units after it drives the inputs at the falling edge. Writes, frees, grab marking and snoop storage take effect one edge later. The bench therefore updates its reference model just after the rising edge and compares `valid_o` and the response fields in the next sampled cycle. Same-cycle collisions are covered by directed steps, such as a free together with a reuse of the same tag, or a merge while the table is full. Random traffic then keeps addresses unique among live slots.

// File: rtl/ort_pkg.sv
package ort_pkg;

  typedef enum logic [1:0] {
    REQ_RD   = 2'd0,
    REQ_RDX  = 2'd1,
    REQ_UPGR = 2'd2,
    REQ_WB   = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    SN_INV = 2'd0,
    SN_SHR = 2'd1,
    SN_EXC = 2'd2,
    SN_MOD = 2'd3
  } snoop_e;

  typedef struct packed {
    req_kind_e kind;
    logic      grab;
    logic      orig;
    snoop_e    snoop;
    logic      known;
  } ent_info_t;

  // only kinds that wait for a data response hold a slot
  function automatic logic waits_for_data(req_kind_e k);
    return (k == REQ_RD) || (k == REQ_RDX);
  endfunction

endpackage

// File: rtl/ort_entry.sv
module ort_entry
  import ort_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  req_kind_e         alloc_kind_i,
  input  logic              alloc_own_i,
  input  logic              free_i,
  input  logic              grab_i,
  input  logic              snoop_i,
  input  snoop_e            snoop_state_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output ent_info_t         info_o
);

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  ent_info_t         info_q;

  // priority: new allocation, then release, then flag updates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      info_q  <= '0;
    end else if (alloc_i) begin
      valid_q      <= 1'b1;
      addr_q       <= alloc_addr_i;
      info_q.kind  <= alloc_kind_i;
      info_q.grab  <= alloc_own_i;
      info_q.orig  <= alloc_own_i;
      info_q.snoop <= SN_INV;
      info_q.known <= 1'b0;
    end else if (free_i) begin
      valid_q <= 1'b0;
      info_q  <= '0;
    end else if (valid_q) begin
      if (grab_i) info_q.grab <= 1'b1;
      if (snoop_i) begin
        info_q.snoop <= snoop_state_i;
        info_q.known <= 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign info_o  = info_q;

  // R8
  grab_on_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grab_i |-> valid_q);

  // R8
  merge_keeps_orig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grab_i && !alloc_i && !free_i |=> $stable(info_q.orig) && info_q.grab);

endmodule

// File: rtl/ort_match.sv
module ort_match #(
  parameter int ADDR_W = 32,
  parameter int N      = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N-1:0]               valid_i,
  input  logic [N-1:0][ADDR_W-1:0]   addr_i,
  input  logic [ADDR_W-1:0]          key_i,
  output logic [N-1:0]               hit_vec_o,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           hit_idx_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (addr_i[g] == key_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec_o[i]) hit_idx_o = i[IDX_W-1:0];
    end
  end

  // R6
  unique_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o));

endmodule

// File: rtl/ort_issue_ctl.sv
module ort_issue_ctl
  import ort_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  req_kind_e kind_i,
  input  logic      hit_i,
  input  req_kind_e hit_kind_i,
  input  logic      full_i,
  output logic      issue_o,
  output logic      merge_o,
  output logic      retry_o
);

  logic compatible;

  always_comb begin
    compatible = (kind_i == REQ_RD) && (hit_kind_i == REQ_RD);
    merge_o    = req_i && hit_i && compatible;
    retry_o    = req_i && (hit_i ? !compatible : full_i);
    issue_o    = req_i && !hit_i && !full_i;
  end

  // R11
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> $countones({issue_o, merge_o, retry_o}) == 1);

  // R11
  idle_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(issue_o || merge_o || retry_o));

  // R9
  conflict_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && req_i && (kind_i != REQ_RD) |-> retry_o);

endmodule

// File: rtl/ort_table.sv
module ort_table
  import ort_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 3,
  localparam int N     = 1 << TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_valid_i,
  input  logic [TAG_W-1:0]  bus_req_tag_i,
  input  logic [ADDR_W-1:0] bus_req_addr_i,
  input  logic [1:0]        bus_req_kind_i,
  input  logic              bus_req_own_i,
  input  logic              snoop_valid_i,
  input  logic [TAG_W-1:0]  snoop_tag_i,
  input  logic [1:0]        snoop_state_i,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic              cpu_req_valid_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic [1:0]        cpu_req_kind_i,
  output logic              cpu_issue_o,
  output logic              cpu_merge_o,
  output logic              cpu_retry_o,
  output logic              bus_hit_o,
  output logic              full_o,
  output logic [N-1:0]      valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_grab_o,
  output logic              rsp_orig_o,
  output logic              rsp_snoop_known_o,
  output logic [1:0]        rsp_snoop_o
);

  logic [N-1:0]             ent_valid;
  logic [N-1:0][ADDR_W-1:0] ent_addr;
  ent_info_t [N-1:0]        ent_info;

  logic [N-1:0]             cpu_hit_vec;
  logic                     cpu_hit;
  logic [TAG_W-1:0]         cpu_hit_idx;
  logic [N-1:0]             bus_hit_vec;
  logic                     bus_hit_any;
  logic [TAG_W-1:0]         bus_hit_idx;

  req_kind_e bus_kind;
  req_kind_e cpu_kind;
  logic      bus_alloc;

  assign bus_kind  = req_kind_e'(bus_req_kind_i);
  assign cpu_kind  = req_kind_e'(cpu_req_kind_i);
  assign bus_alloc = bus_req_valid_i && waits_for_data(bus_kind);

  for (genvar g = 0; g < N; g++) begin : g_slot
    ort_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .alloc_i       (bus_alloc && (bus_req_tag_i == TAG_W'(g))),
      .alloc_addr_i  (bus_req_addr_i),
      .alloc_kind_i  (bus_kind),
      .alloc_own_i   (bus_req_own_i),
      .free_i        (rsp_valid_i && (rsp_tag_i == TAG_W'(g))),
      .grab_i        (cpu_merge_o && cpu_hit_vec[g]),
      .snoop_i       (snoop_valid_i && (snoop_tag_i == TAG_W'(g))),
      .snoop_state_i (snoop_e'(snoop_state_i)),
      .valid_o       (ent_valid[g]),
      .addr_o        (ent_addr[g]),
      .info_o        (ent_info[g])
    );
  end

  ort_match #(.ADDR_W(ADDR_W), .N(N)) u_cpu_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (ent_valid),
    .addr_i    (ent_addr),
    .key_i     (cpu_req_addr_i),
    .hit_vec_o (cpu_hit_vec),
    .hit_o     (cpu_hit),
    .hit_idx_o (cpu_hit_idx)
  );

  ort_match #(.ADDR_W(ADDR_W), .N(N)) u_bus_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (ent_valid),
    .addr_i    (ent_addr),
    .key_i     (bus_req_addr_i),
    .hit_vec_o (bus_hit_vec),
    .hit_o     (bus_hit_any),
    .hit_idx_o (bus_hit_idx)
  );

  ort_issue_ctl u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (cpu_req_valid_i),
    .kind_i     (cpu_kind),
    .hit_i      (cpu_hit),
    .hit_kind_i (ent_info[cpu_hit_idx].kind),
    .full_i     (full_o),
    .issue_o    (cpu_issue_o),
    .merge_o    (cpu_merge_o),
    .retry_o    (cpu_retry_o)
  );

  ent_info_t rsp_info;

  always_comb begin
    full_o            = &ent_valid;
    valid_o           = ent_valid;
    bus_hit_o         = bus_req_valid_i && bus_hit_any;
    rsp_hit_o         = rsp_valid_i && ent_valid[rsp_tag_i];
    rsp_info          = rsp_hit_o ? ent_info[rsp_tag_i] : '0;
    rsp_grab_o        = rsp_info.grab;
    rsp_orig_o        = rsp_info.orig;
    rsp_snoop_known_o = rsp_info.known;
    rsp_snoop_o       = rsp_info.snoop;
  end

  // R2
  alloc_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_valid_i && !bus_req_kind_i[1] |=> valid_o[$past(bus_req_tag_i)]);

  // R3
  no_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_valid_i && bus_req_kind_i[1] && !valid_o[bus_req_tag_i]
    |=> !valid_o[$past(bus_req_tag_i)]);

  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && !(bus_req_valid_i && !bus_req_kind_i[1] && bus_req_tag_i == rsp_tag_i)
    |=> !valid_o[$past(rsp_tag_i)]);

  // R10
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_valid_i && full_o |-> !cpu_issue_o);

  // R8
  merge_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_merge_o |-> cpu_req_kind_i == 2'd0);

endmodule

// File: tb/ort_table_test.sv
`timescale 1ns/1ps
module ort_table_test;

  localparam int AW = 32;
  localparam int TW = 3;
  localparam int NS = 1 << TW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_req_valid_i = 1'b0;
  logic [TW-1:0] bus_req_tag_i = '0;
  logic [AW-1:0] bus_req_addr_i = '0;
  logic [1:0]    bus_req_kind_i = '0;
  logic          bus_req_own_i = 1'b0;
  logic          snoop_valid_i = 1'b0;
  logic [TW-1:0] snoop_tag_i = '0;
  logic [1:0]    snoop_state_i = '0;
  logic          rsp_valid_i = 1'b0;
  logic [TW-1:0] rsp_tag_i = '0;
  logic          cpu_req_valid_i = 1'b0;
  logic [AW-1:0] cpu_req_addr_i = '0;
  logic [1:0]    cpu_req_kind_i = '0;
  logic          cpu_issue_o, cpu_merge_o, cpu_retry_o, bus_hit_o, full_o;
  logic [NS-1:0] valid_o;
  logic          rsp_hit_o, rsp_grab_o, rsp_orig_o, rsp_snoop_known_o;
  logic [1:0]    rsp_snoop_o;

  always #5 clk = ~clk;

  ort_table #(.ADDR_W(AW), .TAG_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_req_valid_i(bus_req_valid_i), .bus_req_tag_i(bus_req_tag_i),
    .bus_req_addr_i(bus_req_addr_i), .bus_req_kind_i(bus_req_kind_i),
    .bus_req_own_i(bus_req_own_i),
    .snoop_valid_i(snoop_valid_i), .snoop_tag_i(snoop_tag_i), .snoop_state_i(snoop_state_i),
    .rsp_valid_i(rsp_valid_i), .rsp_tag_i(rsp_tag_i),
    .cpu_req_valid_i(cpu_req_valid_i), .cpu_req_addr_i(cpu_req_addr_i),
    .cpu_req_kind_i(cpu_req_kind_i),
    .cpu_issue_o(cpu_issue_o), .cpu_merge_o(cpu_merge_o), .cpu_retry_o(cpu_retry_o),
    .bus_hit_o(bus_hit_o), .full_o(full_o), .valid_o(valid_o),
    .rsp_hit_o(rsp_hit_o), .rsp_grab_o(rsp_grab_o), .rsp_orig_o(rsp_orig_o),
    .rsp_snoop_known_o(rsp_snoop_known_o), .rsp_snoop_o(rsp_snoop_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit            mv[NS];
  logic [AW-1:0] ma[NS];
  logic [1:0]    mk[NS];
  bit            mg[NS], mo[NS], mkn[NS];
  logic [1:0]    ms[NS];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    bus_req_valid_i = 1'b0; snoop_valid_i = 1'b0;
    rsp_valid_i = 1'b0; cpu_req_valid_i = 1'b0;
  endtask

  task automatic bus(input int t, input logic [AW-1:0] a, input int k, input bit own);
    bus_req_valid_i = 1'b1; bus_req_tag_i = TW'(t); bus_req_addr_i = a;
    bus_req_kind_i = 2'(k); bus_req_own_i = own;
  endtask

  task automatic cpu(input logic [AW-1:0] a, input int k);
    cpu_req_valid_i = 1'b1; cpu_req_addr_i = a; cpu_req_kind_i = 2'(k);
  endtask

  task automatic rsp(input int t);
    rsp_valid_i = 1'b1; rsp_tag_i = TW'(t);
  endtask

  task automatic settle();
    #2;
  endtask

  // compare every output against the model, then advance one clock
  task automatic adv();
    int hit;
    bit full, bhit, e_iss, e_mrg, e_rty, e_rh;
    logic [NS-1:0] vv;
    hit = -1; full = 1'b1; bhit = 1'b0; vv = '0;
    for (int i = 0; i < NS; i++) begin
      vv[i] = mv[i];
      if (!mv[i]) full = 1'b0;
      if (mv[i] && ma[i] == cpu_req_addr_i) hit = i;
      if (mv[i] && ma[i] == bus_req_addr_i && bus_req_valid_i) bhit = 1'b1;
    end
    e_iss = 0; e_mrg = 0; e_rty = 0;
    if (cpu_req_valid_i) begin
      if (hit >= 0) begin
        if (mk[hit] == 2'd0 && cpu_req_kind_i == 2'd0) e_mrg = 1; else e_rty = 1;
      end else if (full) e_rty = 1;
      else e_iss = 1;
    end
    e_rh = rsp_valid_i && mv[rsp_tag_i];
    chk(valid_o == vv, "R2/R3/R4 valid_o", 64'(valid_o), 64'(vv));
    chk(full_o == full, "R10 full_o", 64'(full_o), 64'(full));
    chk(bus_hit_o == bhit, "R6 bus_hit_o", 64'(bus_hit_o), 64'(bhit));
    chk(cpu_issue_o == e_iss, "R7 cpu_issue_o", 64'(cpu_issue_o), 64'(e_iss));
    chk(cpu_merge_o == e_mrg, "R8 cpu_merge_o", 64'(cpu_merge_o), 64'(e_mrg));
    chk(cpu_retry_o == e_rty, "R9 cpu_retry_o", 64'(cpu_retry_o), 64'(e_rty));
    chk(rsp_hit_o == e_rh, "R2 rsp_hit_o", 64'(rsp_hit_o), 64'(e_rh));
    chk(rsp_grab_o == (e_rh && mg[rsp_tag_i]), "R8 rsp_grab_o", 64'(rsp_grab_o), 64'(e_rh && mg[rsp_tag_i]));
    chk(rsp_orig_o == (e_rh && mo[rsp_tag_i]), "R2 rsp_orig_o", 64'(rsp_orig_o), 64'(e_rh && mo[rsp_tag_i]));
    chk(rsp_snoop_known_o == (e_rh && mkn[rsp_tag_i]), "R5 rsp_snoop_known_o",
        64'(rsp_snoop_known_o), 64'(e_rh && mkn[rsp_tag_i]));
    chk(rsp_snoop_o == (e_rh ? ms[rsp_tag_i] : 2'd0), "R5 rsp_snoop_o",
        64'(rsp_snoop_o), 64'(e_rh ? ms[rsp_tag_i] : 2'd0));
    @(posedge clk);
    if (e_mrg) mg[hit] = 1;
    if (snoop_valid_i && mv[snoop_tag_i]) begin
      ms[snoop_tag_i] = snoop_state_i; mkn[snoop_tag_i] = 1;
    end
    if (rsp_valid_i) begin
      mv[rsp_tag_i] = 0; mg[rsp_tag_i] = 0; mo[rsp_tag_i] = 0;
      mkn[rsp_tag_i] = 0; ms[rsp_tag_i] = 0; mk[rsp_tag_i] = 0;
    end
    if (bus_req_valid_i && !bus_req_kind_i[1]) begin
      mv[bus_req_tag_i] = 1; ma[bus_req_tag_i] = bus_req_addr_i;
      mk[bus_req_tag_i] = bus_req_kind_i; mg[bus_req_tag_i] = bus_req_own_i;
      mo[bus_req_tag_i] = bus_req_own_i; ms[bus_req_tag_i] = 0; mkn[bus_req_tag_i] = 0;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, R11 stimulus did not finish actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      mv[i] = 0; ma[i] = 0; mk[i] = 0; mg[i] = 0; mo[i] = 0; mkn[i] = 0; ms[i] = 0;
    end
    repeat (3) @(negedge clk);
    rsp(0);
    settle();
    // R1 reset state
    chk(valid_o == '0, "R1 valid_o", 64'(valid_o), 64'd0);
    chk(full_o == 1'b0, "R1 full_o", 64'(full_o), 64'd0);
    chk(rsp_hit_o == 1'b0, "R1 rsp_hit_o", 64'(rsp_hit_o), 64'd0);
    idle();
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 own read tag 2, foreign read tag 3, foreign exclusive tag 4
    bus(2, 32'h100, 0, 1); settle(); adv();
    bus(3, 32'h200, 0, 0); settle(); adv();
    bus(4, 32'h300, 1, 0); settle(); adv();
    // R3 writeback and upgrade make no slot
    bus(5, 32'h400, 3, 1); settle(); adv();
    bus(6, 32'h500, 2, 1); settle();
    chk(valid_o == 8'b0001_1100, "R3 no slot for writeback", 64'(valid_o), 64'h1c);
    adv();
    chk(valid_o == 8'b0001_1100, "R3 no slot for upgrade", 64'(valid_o), 64'h1c);
    // R6 bus hit
    bus(6, 32'h300, 2, 0); settle();
    chk(bus_hit_o == 1'b1, "R6 bus_hit_o", 64'(bus_hit_o), 64'd1);
    adv();
    // R8 merge into foreign read
    cpu(32'h200, 0); settle();
    chk(cpu_merge_o == 1'b1, "R8 merge", 64'(cpu_merge_o), 64'd1);
    adv();
    // R9 read against pending exclusive read
    cpu(32'h300, 0); settle();
    chk(cpu_retry_o == 1'b1, "R9 retry", 64'(cpu_retry_o), 64'd1);
    adv();
    cpu(32'h100, 1); settle();
    chk(cpu_retry_o == 1'b1, "R9 exclusive vs read", 64'(cpu_retry_o), 64'd1);
    adv();
    // R7 unmatched
    cpu(32'h400, 0); settle();
    chk(cpu_issue_o == 1'b1, "R7 issue", 64'(cpu_issue_o), 64'd1);
    adv();
    // R5 snoop stored, R8 flags reported
    snoop_valid_i = 1'b1; snoop_tag_i = 3'd3; snoop_state_i = 2'd1;
    rsp(2); settle();
    chk(rsp_snoop_known_o == 1'b0, "R5 unknown before snoop", 64'(rsp_snoop_known_o), 64'd0);
    chk(rsp_orig_o == 1'b1 && rsp_grab_o == 1'b1, "R2 own flags", 64'({rsp_orig_o, rsp_grab_o}), 64'd3);
    adv();
    rsp(3); settle();
    chk(rsp_grab_o == 1'b1 && rsp_orig_o == 1'b0, "R8 grab set orig clear",
        64'({rsp_grab_o, rsp_orig_o}), 64'd2);
    chk(rsp_snoop_known_o == 1'b1 && rsp_snoop_o == 2'd1, "R5 stored snoop",
        64'({rsp_snoop_known_o, rsp_snoop_o}), 64'd5);
    adv();
    rsp(4); settle(); adv();
    cpu(32'h300, 0); settle();
    chk(cpu_issue_o == 1'b1, "R9 issue after free", 64'(cpu_issue_o), 64'd1);
    adv();
    // R10 fill every slot, slot 7 a read
    for (int t = 0; t < NS; t++) begin
      bus(t, 32'h1000 + 32'(t) * 64, (t == 7) ? 0 : 1, 0); settle(); adv();
    end
    cpu(32'h9000, 0); settle();
    chk(full_o == 1'b1, "R10 full", 64'(full_o), 64'd1);
    chk(cpu_retry_o == 1'b1, "R10 retry when full", 64'(cpu_retry_o), 64'd1);
    adv();
    cpu(32'h1000 + 7 * 64, 0); settle();
    chk(cpu_merge_o == 1'b1, "R8 merge when full", 64'(cpu_merge_o), 64'd1);
    adv();
    // R4 free and reuse of tag 5 in one cycle
    rsp(5); bus(5, 32'h7700, 0, 1); settle(); adv();
    rsp(5); settle();
    chk(rsp_hit_o == 1'b1 && rsp_orig_o == 1'b1, "R4 reuse wins", 64'({rsp_hit_o, rsp_orig_o}), 64'd3);
    adv();
    chk(valid_o[5] == 1'b0, "R4 freed", 64'(valid_o[5]), 64'd0);
    for (int t = 0; t < NS; t++) begin
      rsp(t); settle(); adv();
    end

    // random traffic, addresses unique among live slots
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 2 == 0) begin
        int t;
        logic [AW-1:0] a;
        bit clash;
        t = int'($urandom % NS);
        a = AW'(($urandom % 16) * 64);
        clash = 0;
        for (int i = 0; i < NS; i++) if (mv[i] && ma[i] == a) clash = 1;
        if (!mv[t] && !clash) bus(t, a, int'($urandom % 4), bit'($urandom % 2));
      end
      if ($urandom % 3 == 0) rsp(int'($urandom % NS));
      if ($urandom % 3 == 0) begin
        snoop_valid_i = 1'b1; snoop_tag_i = TW'($urandom % NS); snoop_state_i = 2'($urandom % 4);
      end
      if ($urandom % 3 != 0) cpu(AW'(($urandom % 16) * 64), int'($urandom % 4));
      settle();
      if (cpu_req_valid_i)
        chk($countones({cpu_issue_o, cpu_merge_o, cpu_retry_o}) == 1, "R11 one outcome",
            64'({cpu_issue_o, cpu_merge_o, cpu_retry_o}), 64'd1);
      adv();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule